// File: doc/BRIEF.md
# Transfer Descriptor Loader

This unit fetches the next transfer descriptor for one channel of a descriptor-chained DMA engine. A descriptor is four 32-bit words stored at consecutive word addresses. The channel controller pulses `start_i` and presents two inputs: the channel's current next-descriptor pointer and its compare status. The loader then picks the descriptor address and reads the four words through a simple read port. That port carries one request at a time; a request stays up until the memory answers with a valid word.

When the fourth word arrives, the unit does four things in one step. It writes the chain pointer, source address, target address and command words to its output registers. It word-aligns any address that a peripheral paces (flow control). It gives a single done pulse. Alongside that pulse it gives a start-interrupt pulse when the command asks for one. A pointer can also select a branch. When branching is enabled in the pointer and the compare status is set, the unit reads an alternate descriptor placed 32 bytes after the normal one.

Top module: `dma_desc_fetch`

## Requirements
- R1: The descriptor base address is `next_desc_i` with its low four bits cleared, when no branch is taken.
- R2: When `next_desc_i` bit 1 is set and `cmp_status_i` is high at the start cycle, the base address is increased by 32. If either condition is missing, no offset is applied.
- R3: Each fetch issues exactly four reads, one at a time, at base, base+4, base+8 and base+12 in that order. `rd_req_o` stays high with a stable `rd_addr_o` until the cycle in which `rd_valid_i` is high. A `rd_valid_i` while no request is pending has no effect.
- R4: The words map to outputs in arrival order: the first to `next_o`, the second to `src_o`, the third to `dst_o` and the fourth to `cmd_o`. None of these outputs changes before the fourth word is accepted. They all update together in the cycle after it, in which `done_o` is high for exactly one cycle.
- R5: If command bit 29 (source paced) is set, bits 1:0 of `src_o` are loaded as zero.
- R6: If command bit 28 (target paced) is set, bits 1:0 of `dst_o` are loaded as zero.
- R7: `start_set_o` pulses together with `done_o` if and only if command bit 22 is set.
- R8: `busy_o` is high from the cycle after an accepted start until the cycle `done_o` rises. A `start_i` while busy is ignored, whatever its pointer.
- R9: After reset, all outputs are zero and no request is pending.
- R10: `chain_end_o` equals bit 0 of the loaded chain-pointer word. This is the stop flag that marks the last descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to fetch a descriptor |
| next_desc_i | input | AW | Current next-descriptor pointer of the channel |
| cmp_status_i | input | 1 | Channel compare status, selects the branch |
| busy_o | output | 1 | Fetch in progress |
| rd_req_o | output | 1 | Read request to memory |
| rd_addr_o | output | AW | Read word address |
| rd_valid_i | input | 1 | Read data valid, completes the pending request |
| rd_data_i | input | DW | Read data |
| next_o | output | DW | Loaded chain-pointer word |
| src_o | output | DW | Loaded source address |
| dst_o | output | DW | Loaded target address |
| cmd_o | output | DW | Loaded command word |
| chain_end_o | output | 1 | Stop flag of the loaded descriptor |
| start_set_o | output | 1 | Start-interrupt status set pulse |
| done_o | output | 1 | Descriptor loaded pulse |

## Verification
The address rule is tried with four kinds of pointer. Set low bits with no branch show the masking. Branch enable with and without compare status shows that both conditions are needed for the 32-byte offset, and compare status without branch enable shows the same. Descriptors carry no pacing flag, source pacing only, target pacing only and both flags, each with unaligned addresses, so each alignment rule is separated from the other. Memory latency runs from zero to three cycles to expose early or late register updates. Stray valid strobes while idle, starts raised mid-fetch and a start held high across a completion test the start and handshake rules.

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int BRANCH_OFS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] next_desc_i,
  input  logic          cmp_status_i,
  output logic          busy_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] next_o,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic [DW-1:0] cmd_o,
  output logic          chain_end_o,
  output logic          start_set_o,
  output logic          done_o
);
  localparam int BIT_BRANCH = 1;
  localparam int BIT_STOP   = 0;
  localparam int BIT_STIRQ  = 22;
  localparam int BIT_TPACE  = 28;
  localparam int BIT_SPACE  = 29;

  logic          busy_q, done_q, sset_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] w0_q, w1_q, w2_q;
  logic [DW-1:0] next_q, src_q, dst_q, cmd_q;
  logic [AW-1:0] fetch_addr;
  logic          take, last;

  assign fetch_addr = (next_desc_i & ~AW'(15)) +
                      ((next_desc_i[BIT_BRANCH] && cmp_status_i) ? AW'(BRANCH_OFS) : '0);
  assign take = busy_q && rd_valid_i;
  assign last = take && (idx_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sset_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      w2_q   <= '0;
      next_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cmd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      sset_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          base_q <= fetch_addr;
        end
      end else if (take) begin
        idx_q <= idx_q + 2'd1;
        case (idx_q)
          2'd0: w0_q <= rd_data_i;
          2'd1: w1_q <= rd_data_i;
          2'd2: w2_q <= rd_data_i;
          default: ;
        endcase
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          sset_q <= rd_data_i[BIT_STIRQ];
          next_q <= w0_q;
          src_q  <= rd_data_i[BIT_SPACE] ? {w1_q[DW-1:2], 2'b00} : w1_q;
          dst_q  <= rd_data_i[BIT_TPACE] ? {w2_q[DW-1:2], 2'b00} : w2_q;
          cmd_q  <= rd_data_i;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign rd_req_o    = busy_q;
  assign rd_addr_o   = base_q + AW'({idx_q, 2'b00});
  assign next_o      = next_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cmd_o       = cmd_q;
  assign chain_end_o = next_q[BIT_STOP];
  assign start_set_o = sset_q;
  assign done_o      = done_q;
endmodule

module dma_desc_fetch_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_valid_i,
  input logic [DW-1:0] src_o,
  input logic [DW-1:0] dst_o,
  input logic [DW-1:0] cmd_o,
  input logic [DW-1:0] next_o,
  input logic          start_set_o,
  input logic          done_o
);
  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  a_r3_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && rd_valid_i && rd_addr_o[3:2] != 2'd3 |=> rd_req_o && rd_addr_o == $past(rd_addr_o) + AW'(4));
  a_r4_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r4_hold_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(src_o) && $stable(dst_o) && $stable(cmd_o) && $stable(next_o));
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r5_src_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cmd_o[29] |-> src_o[1:0] == 2'b00);
  a_r6_dst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cmd_o[28] |-> dst_o[1:0] == 2'b00);
  a_r7_start_flag: assert property (@(posedge clk) disable iff (!rst_n)
    start_set_o |-> done_o && cmd_o[22]);
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !rd_valid_i |=> busy_o && $stable(rd_addr_o));
endmodule

bind dma_desc_fetch dma_desc_fetch_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
  .src_o(src_o), .dst_o(dst_o), .cmd_o(cmd_o), .next_o(next_o),
  .start_set_o(start_set_o), .done_o(done_o)
);

// File: tb/dma_desc_fetch_tb.sv
module dma_desc_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] next_desc_i = '0;
  logic        cmp_status_i = 1'b0;
  logic        busy_o, rd_req_o, rd_valid_i, chain_end_o, start_set_o, done_o;
  logic [31:0] rd_addr_o, rd_data_i, next_o, src_o, dst_o, cmd_o;

  always #5 clk = ~clk;

  dma_desc_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .next_desc_i(next_desc_i),
    .cmp_status_i(cmp_status_i), .busy_o(busy_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .next_o(next_o), .src_o(src_o), .dst_o(dst_o), .cmd_o(cmd_o),
    .chain_end_o(chain_end_o), .start_set_o(start_set_o), .done_o(done_o)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int lat = 0;
  int wait_cnt = 0;
  bit stray = 1'b0;
  bit started = 1'b0;

  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h0BC3_5A07;
  endfunction

  task automatic put(logic [31:0] b, logic [31:0] n, logic [31:0] s, logic [31:0] d, logic [31:0] c);
    mem[b] = n; mem[b + 4] = s; mem[b + 8] = d; mem[b + 12] = c;
  endtask

  // Memory responder
  initial rd_valid_i = 1'b0;
  initial rd_data_i = '0;
  always @(negedge clk) begin
    rd_valid_i <= 1'b0;
    if (rd_req_o) begin
      if (wait_cnt >= lat) begin
        rd_valid_i <= 1'b1;
        rd_data_i  <= mem_rd(rd_addr_o);
        wait_cnt   <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end else begin
      wait_cnt <= 0;
      if (stray) begin
        rd_valid_i <= 1'b1;
        rd_data_i  <= 32'hDEAD_BEEF;
      end
    end
  end

  // Reference model
  logic [31:0] q[$];
  logic [31:0] e_base = '0, e_next = '0, e_src = '0, e_dst = '0, e_cmd = '0;
  bit e_busy = 0, e_done = 0, e_sset = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_busy = 0; e_done = 0; e_sset = 0; q.delete();
      e_base = '0; e_next = '0; e_src = '0; e_dst = '0; e_cmd = '0;
    end else begin
      e_done = 0; e_sset = 0;
      if (!e_busy) begin
        if (start_i) begin
          e_busy = 1;
          q.delete();
          e_base = {next_desc_i[31:4], 4'h0};
          if (next_desc_i[1] && cmp_status_i) e_base = e_base + 32;
        end
      end else if (rd_valid_i) begin
        q.push_back(rd_data_i);
        if (q.size() == 4) begin
          e_next = q[0];
          e_src  = q[3][29] ? (q[1] & 32'hFFFF_FFFC) : q[1];
          e_dst  = q[3][28] ? (q[2] & 32'hFFFF_FFFC) : q[2];
          e_cmd  = q[3];
          e_sset = q[3][22];
          e_done = 1;
          e_busy = 0;
          q.delete();
        end
      end
    end
    if (rst_n) started = 1'b1;
  end

  task automatic cmp1(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n && cycles > 1) begin
      cmp1("R9 reset outputs", {busy_o, rd_req_o, done_o, start_set_o, chain_end_o},
           32'h0);
      cmp1("R9 reset registers", next_o | src_o | dst_o | cmd_o, 32'h0);
    end else if (started) begin
      cmp1("R8 busy", {31'h0, busy_o}, {31'h0, e_busy});
      cmp1("R3 request", {31'h0, rd_req_o}, {31'h0, e_busy});
      if (e_busy) cmp1("R1 R2 R3 address", rd_addr_o, e_base + 32'(q.size() * 4));
      cmp1("R4 done", {31'h0, done_o}, {31'h0, e_done});
      cmp1("R4 R10 next", next_o, e_next);
      cmp1("R10 stop flag", {31'h0, chain_end_o}, {31'h0, e_next[0]});
      cmp1("R5 source", src_o, e_src);
      cmp1("R6 target", dst_o, e_dst);
      cmp1("R4 command", cmd_o, e_cmd);
      cmp1("R7 start flag", {31'h0, start_set_o}, {31'h0, e_sset});
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic fetch(logic [31:0] nd, bit cmp, int l, bit poke);
    @(negedge clk);
    lat = l; next_desc_i = nd; cmp_status_i = cmp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      next_desc_i = 32'h0000_0402; cmp_status_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!e_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    put(32'h100, 32'h0000_0200, 32'h1000_0003, 32'h2000_0002, 32'h0040_0010);
    put(32'h120, 32'h0000_0301, 32'h0000_0011, 32'h0000_0022, 32'h3000_0020);
    put(32'h200, 32'h0000_0100, 32'h0000_5557, 32'h0000_6663, 32'h2000_0000);
    put(32'h300, 32'h0000_0121, 32'h0000_7771, 32'h0000_8883, 32'h1040_0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fetch(32'h0000_0100, 1'b0, 0, 1'b0); // R1 R7 no pacing
    fetch(32'h0000_0102, 1'b1, 1, 1'b0); // R2 branch taken, R5 R6 R10
    fetch(32'h0000_0102, 1'b0, 2, 1'b0); // R2 no compare status
    fetch(32'h0000_0101, 1'b1, 0, 1'b0); // R2 branch disabled
    fetch(32'h0000_020F, 1'b0, 3, 1'b0); // R1 low bits, R5 only
    fetch(32'h0000_0300, 1'b0, 1, 1'b0); // R6 only, R7
    fetch(32'h0000_030E, 1'b1, 2, 1'b0); // R2 default memory
    fetch(32'h0000_0100, 1'b0, 3, 1'b1); // R8 start while busy
    stray = 1'b1;                        // R3 valid while idle
    repeat (6) @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    lat = 0; next_desc_i = 32'h0000_0122; cmp_status_i = 1'b1; start_i = 1'b1;
    repeat (20) @(negedge clk);          // R8 start held across completion
    start_i = 1'b0;
    while (e_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule